// File: doc/BRIEF.md
# Video Memory Access Port with Programmable Step

This block sits between a processor bus and a word-wide video memory. Software reaches the memory only indirectly. It loads a pointer register, then pushes words through a data window. After each push the pointer moves by a programmable signed step, so columns, rows or strided tables can be filled with one store per word. Reads through the pointer or the window return the word under the pointer without moving it. Read data comes back one cycle after the request, together with a valid strobe.

The same small register file holds four more things. The first is a 32-bit timer reload value, written as an upper half and a lower half. The second is a display-mode control word, whose fields leave the block as outputs. The third is a status read-back, made of the raster line, the field-rate flag and the animation counter supplied by the display timing logic. The fourth is a three-bit set of sticky interrupt-pending flags. Those flags are raised by single-cycle event pulses and cleared through an acknowledge register.

The memory model holds 2^MEM_AW words and is indexed by the low bits of the 16-bit pointer. Pointer arithmetic always wraps over the full 16-bit range.

Top module: `vmp_port`

## Requirements
- R1: After synchronous reset, the pointer, the step, the timer reload value, the mode fields and all pending flags are zero, and `rd_valid` is low.
- R2: A write at byte offset 0 loads the pointer. A read at offset 0 or offset 2 returns the memory word at the pointer and leaves the pointer unchanged.
- R3: A write at byte offset 2 stores the write data into memory at the pointer. In the same cycle the pointer becomes (pointer + step) mod 2^16, with the step taken as a signed 16-bit value, so 16'hFFFF moves the pointer down by one.
- R4: A write at byte offset 4 loads the step, and a read at offset 4 returns it.
- R5: A byte access (`bus_byte`=1) at an even offset acts as a word access whose data is `bus_wdata[7:0]` copied into both bytes.
- R6: An access with `bus_addr[0]`=1, or a write at offset 14, changes no state. A read at an odd offset, or at offset 12 or 14, returns zero.
- R7: A write at offset 8 loads bits 31:16 of `timer_reload`, and a write at offset 10 loads bits 15:0. Reads at offsets 8 and 10 return those halves.
- R8: A write at offset 12 clears each pending flag whose data bit is 1. Bit 2 is the vertical-blank flag, bit 1 the timer flag and bit 0 the third source. These map to `irq_pend[2:0]` and `irq_pulse[2:0]` in the same order.
- R9: A one-cycle pulse on `irq_pulse[i]` sets `irq_pend[i]` at the next edge. This holds even when an acknowledge of that bit happens in the same cycle.
- R10: A write at offset 6 sets `anim_speed` from data bits 15:8, `timer_mode` from bits 7:5, `timer_irq_en` from bit 4 and `anim_disable` from bit 3.
- R11: A read at offset 6 returns {`raster_line`[8:0], 3'b000, `pal_mode`, `anim_count`[2:0]}, with the raster line in bits 15:7.
- R12: `rd_valid` is high for exactly the one cycle after each read request and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_addr | input | 4 | Byte offset inside the register window |
| bus_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 16 | Read data |
| irq_pulse | input | 3 | Event pulses: vblank, timer, third source |
| irq_pend | output | 3 | Sticky pending flags |
| raster_line | input | 9 | Current raster line from display timing |
| pal_mode | input | 1 | Field-rate flag, 1 = 50 Hz |
| anim_count | input | 3 | Auto-animation counter |
| timer_reload | output | 32 | Timer reload value |
| anim_speed | output | 8 | Auto-animation period in frames |
| timer_mode | output | 3 | Timer interrupt mode |
| timer_irq_en | output | 1 | Timer interrupt enable |
| anim_disable | output | 1 | Auto-animation disable |

## Verification
The bench fills memory with positive, zero and negative steps, and it places a store at pointer 16'hFFFF. A design that carried into a wider pointer, or that treated the step as unsigned, would leave words in the wrong cells. Back-to-back reads followed by a store catch a design that advances the pointer on reads. Byte stores and odd-offset accesses catch a design that writes only one byte lane, or that decodes odd addresses onto their even neighbours. An acknowledge that lands in the same cycle as a pulse exposes a design that lets the clear win, which would silently lose an interrupt.

// File: rtl/vmp_pkg.sv
package vmp_pkg;

  // register word index (byte offset >> 1)
  localparam int unsigned IDX_PTR   = 0;
  localparam int unsigned IDX_WIN   = 1;
  localparam int unsigned IDX_STEP  = 2;
  localparam int unsigned IDX_MODE  = 3;
  localparam int unsigned IDX_RLHI  = 4;
  localparam int unsigned IDX_RLLO  = 5;
  localparam int unsigned IDX_ACK   = 6;

  // mode word field positions (write direction)
  localparam int unsigned MW_SPEED_LSB = 8;
  localparam int unsigned MW_SPEED_W   = 8;
  localparam int unsigned MW_TMODE_LSB = 5;
  localparam int unsigned MW_TMODE_W   = 3;
  localparam int unsigned MW_TEN_BIT   = 4;
  localparam int unsigned MW_ADIS_BIT  = 3;

  typedef enum logic [2:0] {
    RSEL_ZERO = 3'd0,
    RSEL_MEM  = 3'd1,
    RSEL_STEP = 3'd2,
    RSEL_MODE = 3'd3,
    RSEL_RLHI = 3'd4,
    RSEL_RLLO = 3'd5
  } rd_sel_e;

  typedef struct packed {
    logic ptr;
    logic win;
    logic step;
    logic mode;
    logic rlhi;
    logic rllo;
    logic ack;
  } wr_strobe_t;

endpackage

// File: rtl/vmp_decode.sv
module vmp_decode
  import vmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int OFS_W  = 4
)(
  input  logic              req,
  input  logic              we,
  input  logic              byte_acc,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  output wr_strobe_t        wstb,
  output logic              rd_req,
  output rd_sel_e           rd_sel,
  output logic [DATA_W-1:0] wdata_eff
);
  localparam int HALF_W = DATA_W / 2;

  logic even_hit;
  assign even_hit = req && !ofs[0];

  // byte stores are mirrored into both lanes
  always_comb begin
    if (byte_acc) wdata_eff = {2{wdata[HALF_W-1:0]}};
    else          wdata_eff = wdata;
  end

  always_comb begin
    wstb = '0;
    if (even_hit && we) begin
      case (int'(ofs[OFS_W-1:1]))
        IDX_PTR:  wstb.ptr  = 1'b1;
        IDX_WIN:  wstb.win  = 1'b1;
        IDX_STEP: wstb.step = 1'b1;
        IDX_MODE: wstb.mode = 1'b1;
        IDX_RLHI: wstb.rlhi = 1'b1;
        IDX_RLLO: wstb.rllo = 1'b1;
        IDX_ACK:  wstb.ack  = 1'b1;
        default:  wstb      = '0;
      endcase
    end
  end

  assign rd_req = req && !we;

  always_comb begin
    rd_sel = RSEL_ZERO;
    if (even_hit && !we) begin
      case (int'(ofs[OFS_W-1:1]))
        IDX_PTR, IDX_WIN: rd_sel = RSEL_MEM;
        IDX_STEP:         rd_sel = RSEL_STEP;
        IDX_MODE:         rd_sel = RSEL_MODE;
        IDX_RLHI:         rd_sel = RSEL_RLHI;
        IDX_RLLO:         rd_sel = RSEL_RLLO;
        default:          rd_sel = RSEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/vmp_vram.sv
module vmp_vram #(
  parameter int DATA_W = 16,
  parameter int MEM_AW = 10
)(
  input  logic              clk,
  input  logic              we,
  input  logic [MEM_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [MEM_AW-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/vmp_irq_flags.sv
module vmp_irq_flags #(
  parameter int IRQ_N = 3
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_we,
  input  logic [IRQ_N-1:0] ack_bits,
  input  logic [IRQ_N-1:0] pulse,
  output logic [IRQ_N-1:0] pend
);
  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        pend[i] <= 1'b0;
      else if (pulse[i])
        pend[i] <= 1'b1;          // a new event beats a clear
      else if (ack_we && ack_bits[i])
        pend[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/vmp_port.sv
module vmp_port
  import vmp_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 16,
  parameter int MEM_AW   = 10,
  parameter int OFS_W    = 4,
  parameter int IRQ_N    = 3,
  parameter int RASTER_W = 9,
  parameter int ANIMC_W  = 3
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_req,
  input  logic                  bus_we,
  input  logic                  bus_byte,
  input  logic [OFS_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  input  logic [IRQ_N-1:0]      irq_pulse,
  output logic [IRQ_N-1:0]      irq_pend,
  input  logic [RASTER_W-1:0]   raster_line,
  input  logic                  pal_mode,
  input  logic [ANIMC_W-1:0]    anim_count,
  output logic [2*DATA_W-1:0]   timer_reload,
  output logic [MW_SPEED_W-1:0] anim_speed,
  output logic [MW_TMODE_W-1:0] timer_mode,
  output logic                  timer_irq_en,
  output logic                  anim_disable
);
  localparam int PAD_W = DATA_W - RASTER_W - 1 - ANIMC_W;

  wr_strobe_t        wstb;
  logic              rd_req;
  rd_sel_e           rd_sel;
  logic [DATA_W-1:0] wd;

  vmp_decode #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_dec (
    .req       (bus_req),
    .we        (bus_we),
    .byte_acc  (bus_byte),
    .ofs       (bus_addr),
    .wdata     (bus_wdata),
    .wstb      (wstb),
    .rd_req    (rd_req),
    .rd_sel    (rd_sel),
    .wdata_eff (wd)
  );

  // pointer and signed step
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      step_q <= '0;
    end else begin
      if (wstb.ptr)       ptr_q <= wd[ADDR_W-1:0];
      else if (wstb.win)  ptr_q <= ptr_q + step_q;   // wraps over 2^ADDR_W
      if (wstb.step)      step_q <= wd[ADDR_W-1:0];
    end
  end

  // memory model
  logic [DATA_W-1:0] mem_rd;

  vmp_vram #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_vram (
    .clk   (clk),
    .we    (wstb.win),
    .waddr (ptr_q[MEM_AW-1:0]),
    .wdata (wd),
    .re    (rd_sel == RSEL_MEM),
    .raddr (ptr_q[MEM_AW-1:0]),
    .rdata (mem_rd)
  );

  // timer reload halves
  always_ff @(posedge clk) begin
    if (rst) begin
      timer_reload <= '0;
    end else begin
      if (wstb.rlhi) timer_reload[2*DATA_W-1:DATA_W] <= wd;
      if (wstb.rllo) timer_reload[DATA_W-1:0]        <= wd;
    end
  end

  // mode control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      anim_speed   <= '0;
      timer_mode   <= '0;
      timer_irq_en <= 1'b0;
      anim_disable <= 1'b0;
    end else if (wstb.mode) begin
      anim_speed   <= wd[MW_SPEED_LSB +: MW_SPEED_W];
      timer_mode   <= wd[MW_TMODE_LSB +: MW_TMODE_W];
      timer_irq_en <= wd[MW_TEN_BIT];
      anim_disable <= wd[MW_ADIS_BIT];
    end
  end

  // pending interrupt flags
  vmp_irq_flags #(.IRQ_N(IRQ_N)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .ack_we   (wstb.ack),
    .ack_bits (wd[IRQ_N-1:0]),
    .pulse    (irq_pulse),
    .pend     (irq_pend)
  );

  // read path: one cycle, memory and register sources both registered
  logic [DATA_W-1:0] status_word;
  assign status_word = {raster_line, {PAD_W{1'b0}}, pal_mode, anim_count};

  logic              src_mem_q;
  logic [DATA_W-1:0] reg_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      src_mem_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      rd_valid  <= rd_req;
      src_mem_q <= (rd_sel == RSEL_MEM);
      if (rd_req) begin
        case (rd_sel)
          RSEL_STEP: reg_rd_q <= step_q[DATA_W-1:0];
          RSEL_MODE: reg_rd_q <= status_word;
          RSEL_RLHI: reg_rd_q <= timer_reload[2*DATA_W-1:DATA_W];
          RSEL_RLLO: reg_rd_q <= timer_reload[DATA_W-1:0];
          default:   reg_rd_q <= '0;
        endcase
      end
    end
  end

  assign rd_data = src_mem_q ? mem_rd : reg_rd_q;

  logic lint_unused_bits;
  assign lint_unused_bits = ^{wd[DATA_W-1:IRQ_N], wd[MW_ADIS_BIT-1:0]};

endmodule

// File: rtl/vmp_port_chk.sv
module vmp_port_chk #(
  parameter int OFS_W = 4,
  parameter int IRQ_N = 3,
  parameter int RL_W  = 32,
  parameter int SPD_W = 8
)(
  input logic             clk,
  input logic             rst,
  input logic             bus_req,
  input logic             bus_we,
  input logic [OFS_W-1:0] bus_addr,
  input logic             rd_valid,
  input logic [IRQ_N-1:0] irq_pulse,
  input logic [IRQ_N-1:0] irq_pend,
  input logic [RL_W-1:0]  timer_reload,
  input logic [SPD_W-1:0] anim_speed
);

  // R1: reset clears outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (timer_reload == '0 && irq_pend == '0 && anim_speed == '0 && !rd_valid));

  // R12: valid follows a read request by one cycle
  a_r12_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> rd_valid);

  // R12: no valid without a request
  a_r12_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && !bus_we) |=> !rd_valid);

  // R9: pulse always sets its flag
  a_r9_pulse_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (|irq_pulse) |=> ((irq_pend & $past(irq_pulse)) == $past(irq_pulse)));

  // R8: flag rises only after a pulse
  a_r8_no_rise_without_pulse: assert property (@(posedge clk) disable iff (rst)
    !(|irq_pulse) |=> ((irq_pend & ~$past(irq_pend)) == '0));

  // R7: reload holds when nothing is written
  a_r7_reload_holds: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> $stable(timer_reload));

  // R6: odd writes alter nothing visible
  a_r6_odd_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr[0]) |=> ($stable(timer_reload) && $stable(anim_speed)));

endmodule

bind vmp_port vmp_port_chk #(
  .OFS_W(OFS_W), .IRQ_N(IRQ_N), .RL_W(2*DATA_W), .SPD_W(vmp_pkg::MW_SPEED_W)
) u_vmp_port_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .rd_valid     (rd_valid),
  .irq_pulse    (irq_pulse),
  .irq_pend     (irq_pend),
  .timer_reload (timer_reload),
  .anim_speed   (anim_speed)
);

// File: tb/vmp_port_bench.sv
`timescale 1ns/1ps
module vmp_port_bench;

  localparam logic [3:0] O_PTR  = 4'd0;
  localparam logic [3:0] O_WIN  = 4'd2;
  localparam logic [3:0] O_STEP = 4'd4;
  localparam logic [3:0] O_MODE = 4'd6;
  localparam logic [3:0] O_RLHI = 4'd8;
  localparam logic [3:0] O_RLLO = 4'd10;
  localparam logic [3:0] O_ACK  = 4'd12;
  localparam logic [3:0] O_RSV  = 4'd14;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_req, bus_we, bus_byte;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [2:0]  irq_pulse, irq_pend;
  logic [8:0]  raster_line;
  logic        pal_mode;
  logic [2:0]  anim_count;
  logic [31:0] timer_reload;
  logic [7:0]  anim_speed;
  logic [2:0]  timer_mode;
  logic        timer_irq_en, anim_disable;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  vmp_port u_vmp_port (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .irq_pulse(irq_pulse), .irq_pend(irq_pend), .raster_line(raster_line),
    .pal_mode(pal_mode), .anim_count(anim_count), .timer_reload(timer_reload),
    .anim_speed(anim_speed), .timer_mode(timer_mode), .timer_irq_en(timer_irq_en),
    .anim_disable(anim_disable)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [3:0] ofs, input logic [15:0] d, input logic is_byte = 1'b0);
    bus_req = 1'b1; bus_we = 1'b1; bus_byte = is_byte; bus_addr = ofs; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [3:0] ofs, output logic [15:0] d, output logic v);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = ofs;
    @(negedge clk);
    bus_req = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd_expect(input string req, input logic [3:0] ofs, input logic [15:0] exp);
    logic [15:0] d; logic v;
    rd(ofs, d, v);
    chk({req, " valid"}, {31'd0, v}, 32'd1);
    chk(req, {16'd0, d}, {16'd0, exp});
  endtask

  task automatic t_reset;
    chk("R1 reload", timer_reload, 32'd0);
    chk("R1 pend", {29'd0, irq_pend}, 32'd0);
    chk("R1 mode", {19'd0, anim_speed, timer_mode, timer_irq_en, anim_disable}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    rd_expect("R1 step zero", O_STEP, 16'h0000);
  endtask

  task automatic t_pointer_read;
    logic [15:0] d; logic v;
    wr(O_STEP, 16'h0001);
    wr(O_PTR, 16'h0040);
    wr(O_WIN, 16'hA0A0);              // 0x40, ptr -> 0x41
    wr(O_WIN, 16'hA1A1);              // 0x41, ptr -> 0x42
    wr(O_PTR, 16'h0041);
    rd_expect("R2 read via ptr offset", O_PTR, 16'hA1A1);
    rd_expect("R2 read via window", O_WIN, 16'hA1A1);
    wr(O_WIN, 16'hB5B5);              // must still land at 0x41
    wr(O_PTR, 16'h0041);
    rd_expect("R2 reads keep pointer", O_PTR, 16'hB5B5);
    @(negedge clk);
    chk("R12 valid drops", {31'd0, rd_valid}, 32'd0);
    rd(O_PTR, d, v);
    chk("R12 back-to-back valid", {31'd0, v}, 32'd1);
  endtask

  task automatic t_step_fill;
    wr(O_STEP, 16'h0004);
    rd_expect("R4 step readback", O_STEP, 16'h0004);
    wr(O_PTR, 16'h0100);
    for (int i = 0; i < 4; i++) wr(O_WIN, 16'h1000 + 16'(i));
    for (int i = 0; i < 4; i++) begin
      wr(O_PTR, 16'h0100 + 16'(4*i));
      rd_expect("R3 stride fill", O_WIN, 16'h1000 + 16'(i));
    end
  endtask

  task automatic t_wrap_negative;
    wr(O_STEP, 16'h0002);
    wr(O_PTR, 16'hFFFF);
    wr(O_WIN, 16'hCAFE);              // cell 0x3FF, ptr -> 0x0001
    wr(O_WIN, 16'hBEEF);              // cell 0x001
    wr(O_PTR, 16'h0001);
    rd_expect("R3 wrap lands low", O_PTR, 16'hBEEF);
    wr(O_PTR, 16'hFFFF);
    rd_expect("R3 wrap first", O_PTR, 16'hCAFE);
    wr(O_STEP, 16'hFFFF);             // -1
    wr(O_PTR, 16'h0010);
    wr(O_WIN, 16'h0C0C);
    wr(O_WIN, 16'h0D0D);
    wr(O_PTR, 16'h000F);
    rd_expect("R3 negative step", O_PTR, 16'h0D0D);
    wr(O_PTR, 16'h0010);
    rd_expect("R3 negative first", O_PTR, 16'h0C0C);
  endtask

  task automatic t_byte;
    wr(O_STEP, 16'h0077, 1'b1);
    rd_expect("R5 byte step mirrored", O_STEP, 16'h7777);
    wr(O_PTR, 16'hEE20, 1'b1);        // ptr = 0x2020
    wr(O_WIN, 16'h995A, 1'b1);        // word 0x5A5A at 0x2020
    wr(O_PTR, 16'h2020);
    rd_expect("R5 byte window mirrored", O_WIN, 16'h5A5A);
  endtask

  task automatic t_odd;
    wr(O_RLLO, 16'h1234);
    wr(O_STEP, 16'h0003);
    wr(O_RLLO | 4'd1, 16'hFFFF);
    wr(O_STEP | 4'd1, 16'h00AA, 1'b1);
    wr(O_MODE | 4'd1, 16'hFFFF);
    wr(O_RSV, 16'hFFFF);
    chk("R6 odd reload", timer_reload[15:0], 32'h1234);
    chk("R6 odd mode", {24'd0, anim_speed}, 32'd0);
    rd_expect("R6 odd step kept", O_STEP, 16'h0003);
    rd_expect("R6 odd read zero", O_STEP | 4'd1, 16'h0000);
    rd_expect("R6 ack read zero", O_ACK, 16'h0000);
    rd_expect("R6 reserved read zero", O_RSV, 16'h0000);
  endtask

  task automatic t_reload;
    wr(O_RLHI, 16'hDEAD);
    wr(O_RLLO, 16'h4321);
    chk("R7 reload", timer_reload, 32'hDEAD4321);
    rd_expect("R7 hi read", O_RLHI, 16'hDEAD);
    rd_expect("R7 lo read", O_RLLO, 16'h4321);
  endtask

  task automatic t_irq;
    irq_pulse = 3'b111; @(negedge clk); irq_pulse = 3'b000;
    chk("R9 pulses set", {29'd0, irq_pend}, 32'd7);
    wr(O_ACK, 16'h0004);
    chk("R8 ack vblank", {29'd0, irq_pend}, 32'd3);
    irq_pulse = 3'b010;
    wr(O_ACK, 16'h0002);
    irq_pulse = 3'b000;
    chk("R9 pulse beats ack", {29'd0, irq_pend}, 32'd3);
    wr(O_ACK, 16'h0003);
    chk("R8 ack timer and third", {29'd0, irq_pend}, 32'd0);
    irq_pulse = 3'b100; @(negedge clk); irq_pulse = 3'b000;
    wr(O_ACK, 16'hFF04, 1'b1);
    chk("R8 byte ack", {29'd0, irq_pend}, 32'd0);
  endtask

  task automatic t_mode;
    wr(O_MODE, 16'hA5B8);             // speed A5, mode 101, en 1, dis 1
    chk("R10 speed", {24'd0, anim_speed}, 32'hA5);
    chk("R10 tmode", {29'd0, timer_mode}, 32'd5);
    chk("R10 enable", {31'd0, timer_irq_en}, 32'd1);
    chk("R10 disable", {31'd0, anim_disable}, 32'd1);
    raster_line = 9'h1A5; pal_mode = 1'b1; anim_count = 3'b101;
    rd_expect("R11 status", O_MODE, {9'h1A5, 3'b000, 1'b1, 3'b101});
    raster_line = 9'h003; pal_mode = 1'b0; anim_count = 3'b010;
    rd_expect("R11 status 60Hz", O_MODE, {9'h003, 3'b000, 1'b0, 3'b010});
  endtask

  initial begin
    rst = 1'b1; bus_req = 1'b0; bus_we = 1'b0; bus_byte = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_pulse = '0;
    raster_line = '0; pal_mode = 1'b0; anim_count = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pointer_read();
    t_step_fill();
    t_wrap_negative();
    t_byte();
    t_odd();
    t_reload();
    t_irq();
    t_mode();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule